// File: doc/BRIEF.md
# Branch Target Buffer with Fetch Redirect

This block sits beside the instruction cache in the fetch stage. Each cycle it is looked up with the current fetch address, in parallel with the instruction read. It returns whether that address belongs to a known branch and whether the branch is expected to go. It also returns the address to fetch next: either the remembered destination or the next sequential word. The storage is a small direct-mapped table. Each slot holds a valid flag, an address tag, a destination address and a 2-bit saturating direction counter.

When a branch is decided further down the pipe, the deciding stage reports its address, whether it went, and where it went. The block reads its own table for that address and works out the next address it would have predicted. It compares this with the real outcome, then trains or fills the slot. Only branches ever reach the table, and only branches that actually went cause a new slot to be filled. A wrong guess costs two cycles. These are driven by a small state machine with three states. RUN is normal operation. FLUSH kills the one younger instruction already fetched and holds the fetch address. STALL presents the corrected address as a redirect. The transitions are RUN to FLUSH on a wrong guess, FLUSH to STALL unconditionally, and STALL to RUN unconditionally.

Top module: `btb_fetch_unit`

## Requirements
- R1: After reset every slot is empty. Every lookup misses with predicted-taken low, next_pc equals fetch_pc + 4, and flush, stall and redirect are all low.
- R2: The slot index is PC[IDX_W+1:2] and the tag is PC[PC_W-1:IDX_W+2], where IDX_W = log2(DEPTH). A lookup hits only when the slot is valid and its stored tag equals the tag of fetch_pc. Two addresses with the same index and different tags do not both hit.
- R3: On a hit whose counter is 2 or 3 (bit 1 set), pred_taken is 1 and next_pc equals the stored destination, in the same cycle as fetch_pc is presented.
- R4: On a miss (including any non-branch address), or on a hit whose counter is 0 or 1, pred_taken is 0 and next_pc equals fetch_pc + 4.
- R5: A resolved branch that went and misses in the table fills the slot at its index. The fill writes valid, the tag, the reported destination and counter value 2. A resolved branch that did not go and misses leaves the table unchanged.
- R6: A resolved branch that hits updates its counter. The counter steps up by one when the branch went, saturating at 3, and steps down by one when it did not, saturating at 0. When the branch went, the stored destination is replaced by the reported one.
- R7: A resolve is a misprediction when the table's predicted next address for the resolved PC, read in the resolve cycle, differs from the true next address. The predicted next address is the destination on a hit with counter bit 1 set, else PC + 4. The true next address is the reported destination if the branch went, else PC + 4.
- R8: In the cycle after a misprediction, flush and stall are 1 and next_pc equals fetch_pc. In the following cycle, redirect and stall are 1, flush is 0, and next_pc equals the true next address. In the cycle after that, all three are 0.
- R9: A resolve reported while flush or redirect is high changes no slot and starts no new penalty sequence.
- R10: When a lookup and a write hit the same slot in one cycle, the lookup returns the slot's old contents, and the written contents are seen from the next cycle on.
- R11: A resolve whose prediction was right raises neither flush, stall nor redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| resolve_valid | input | 1 | A branch was decided this cycle |
| resolve_pc | input | PC_W | Address of the decided branch |
| resolve_taken | input | 1 | The decided branch went |
| resolve_target | input | PC_W | Where the decided branch goes when it goes |
| hit | output | 1 | fetch_pc matches a valid slot |
| pred_taken | output | 1 | Hit with counter bit 1 set |
| next_pc | output | PC_W | Address to fetch next |
| flush | output | 1 | Kill the one younger fetched instruction |
| stall | output | 1 | Fetch is held during the penalty |
| redirect | output | 1 | next_pc carries the corrected address |

## Verification
The two functions that can fall in one cycle are the fetch-side lookup and the resolve-side write of the same slot. The bench provokes this by presenting one address as fetch_pc and as a resolved, taken, missing branch on the same clock. The lookup must miss in that cycle and hit in the next. A second overlap is tested by reporting a new resolve while the penalty sequence is running. That resolve must leave no trace in later lookups and must not start a second flush.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_STALL = 2'd2
    } redir_state_e;

    localparam logic [1:0] CTR_FILL = 2'b10;
    localparam logic [1:0] CTR_MAX  = 2'b11;
    localparam logic [1:0] CTR_MIN  = 2'b00;

    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic went);
        logic [1:0] nxt;
        if (went) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        else      nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/btb_entry_array.sv
module btb_entry_array #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int WA_W  = PC_W - 2,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WA_W-1:0] a_wpc,
    output logic            a_hit,
    output logic [1:0]      a_ctr,
    output logic [PC_W-1:0] a_tgt,
    input  logic [WA_W-1:0] b_wpc,
    output logic            b_hit,
    output logic [1:0]      b_ctr,
    output logic [PC_W-1:0] b_tgt,
    input  logic            wr_en,
    input  logic [WA_W-1:0] wr_wpc,
    input  logic [PC_W-1:0] wr_tgt,
    input  logic [1:0]      wr_ctr
);

    logic             vld_a [DEPTH];
    logic [TAG_W-1:0] tag_a [DEPTH];
    logic [PC_W-1:0]  tgt_a [DEPTH];
    logic [1:0]       ctr_a [DEPTH];

    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    assign wr_idx = wr_wpc[IDX_W-1:0];
    assign wr_tag = wr_wpc[WA_W-1:IDX_W];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic [PC_W-1:0]  d_q;
        logic [1:0]       c_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
                d_q <= '0;
                c_q <= 2'b00;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                v_q <= 1'b1;
                t_q <= wr_tag;
                d_q <= wr_tgt;
                c_q <= wr_ctr;
            end
        end

        assign vld_a[i] = v_q;
        assign tag_a[i] = t_q;
        assign tgt_a[i] = d_q;
        assign ctr_a[i] = c_q;
    end

    logic [IDX_W-1:0] a_idx, b_idx;
    assign a_idx = a_wpc[IDX_W-1:0];
    assign b_idx = b_wpc[IDX_W-1:0];

    always_comb begin
        a_hit = vld_a[a_idx] && (tag_a[a_idx] == a_wpc[WA_W-1:IDX_W]);
        a_ctr = ctr_a[a_idx];
        a_tgt = tgt_a[a_idx];
        b_hit = vld_a[b_idx] && (tag_a[b_idx] == b_wpc[WA_W-1:IDX_W]);
        b_ctr = ctr_a[b_idx];
        b_tgt = tgt_a[b_idx];
    end

    // Write tracking for the visibility check below.
    logic            wr_en_q;
    logic [WA_W-1:0] wr_wpc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_q  <= 1'b0;
            wr_wpc_q <= '0;
        end else begin
            wr_en_q  <= wr_en;
            wr_wpc_q <= wr_wpc;
        end
    end

    // R10: a write is seen by a lookup of the same address on the next cycle.
    a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_q && (a_wpc == wr_wpc_q)) |-> a_hit);

endmodule

// File: rtl/btb_resolve_logic.sv
module btb_resolve_logic #(
    parameter int PC_W = 32
) (
    input  logic            res_valid,
    input  logic            accept,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic            b_hit,
    input  logic [1:0]      b_ctr,
    input  logic [PC_W-1:0] b_tgt,
    output logic            mispredict,
    output logic [PC_W-1:0] correct_pc,
    output logic            wr_en,
    output logic [PC_W-1:0] wr_tgt,
    output logic [1:0]      wr_ctr
);
    import btb_pkg::*;

    logic [PC_W-1:0] seq_pc, guess_pc;
    logic            live;

    always_comb begin
        live       = res_valid && accept;
        seq_pc     = res_pc + PC_W'(4);
        guess_pc   = (b_hit && b_ctr[1]) ? b_tgt : seq_pc;
        correct_pc = res_taken ? res_target : seq_pc;
        mispredict = live && (guess_pc != correct_pc);
        wr_en      = live && (b_hit || res_taken);
        wr_ctr     = b_hit ? ctr_step(b_ctr, res_taken) : CTR_FILL;
        wr_tgt     = res_taken ? res_target : b_tgt;
    end

endmodule

// File: rtl/btb_redirect_fsm.sv
module btb_redirect_fsm #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mispredict,
    input  logic [PC_W-1:0] correct_pc,
    output logic            accept,
    output logic            flush,
    output logic            stall,
    output logic            redirect,
    output logic [PC_W-1:0] fix_pc
);
    import btb_pkg::*;

    redir_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (mispredict) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_STALL;
            ST_STALL: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            fix_pc  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && mispredict) fix_pc <= correct_pc;
        end
    end

    always_comb begin
        accept   = 1'b0;
        flush    = 1'b0;
        stall    = 1'b0;
        redirect = 1'b0;
        unique case (state_q)
            ST_RUN:   accept = 1'b1;
            ST_FLUSH: begin flush = 1'b1; stall = 1'b1; end
            ST_STALL: begin redirect = 1'b1; stall = 1'b1; end
            default:  accept = 1'b0;
        endcase
    end

    // R8: the flush cycle is always followed by the redirect cycle.
    a_r8_flush_then_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (redirect && !flush));
    // R8: after the redirect cycle fetch runs freely again.
    a_r8_redirect_then_run: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!stall && !flush && !redirect));
    // R8: flush and redirect never share a cycle.
    a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush, redirect}));

endmodule

// File: rtl/btb_next_pc_mux.sv
module btb_next_pc_mux #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            pred_taken,
    input  logic [PC_W-1:0] pred_tgt,
    input  logic            stall,
    input  logic            redirect,
    input  logic [PC_W-1:0] fix_pc,
    output logic [PC_W-1:0] next_pc
);
    always_comb begin
        if (redirect)        next_pc = fix_pc;
        else if (stall)      next_pc = fetch_pc;
        else if (pred_taken) next_pc = pred_tgt;
        else                 next_pc = fetch_pc + PC_W'(4);
    end
endmodule

// File: rtl/btb_fetch_unit.sv
module btb_fetch_unit #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            resolve_valid,
    input  logic [PC_W-1:0] resolve_pc,
    input  logic            resolve_taken,
    input  logic [PC_W-1:0] resolve_target,
    output logic            hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] next_pc,
    output logic            flush,
    output logic            stall,
    output logic            redirect
);
    localparam int WA_W = PC_W - 2;

    logic            a_hit, b_hit;
    logic [1:0]      a_ctr, b_ctr, wr_ctr;
    logic [PC_W-1:0] a_tgt, b_tgt, wr_tgt;
    logic            wr_en, mispredict, accept;
    logic [PC_W-1:0] correct_pc, fix_pc;

    btb_entry_array #(.PC_W(PC_W), .DEPTH(DEPTH)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_wpc  (fetch_pc[PC_W-1:2]),
        .a_hit  (a_hit),
        .a_ctr  (a_ctr),
        .a_tgt  (a_tgt),
        .b_wpc  (resolve_pc[PC_W-1:2]),
        .b_hit  (b_hit),
        .b_ctr  (b_ctr),
        .b_tgt  (b_tgt),
        .wr_en  (wr_en),
        .wr_wpc (resolve_pc[WA_W+1:2]),
        .wr_tgt (wr_tgt),
        .wr_ctr (wr_ctr)
    );

    btb_resolve_logic #(.PC_W(PC_W)) u_resolve (
        .res_valid  (resolve_valid),
        .accept     (accept),
        .res_pc     (resolve_pc),
        .res_taken  (resolve_taken),
        .res_target (resolve_target),
        .b_hit      (b_hit),
        .b_ctr      (b_ctr),
        .b_tgt      (b_tgt),
        .mispredict (mispredict),
        .correct_pc (correct_pc),
        .wr_en      (wr_en),
        .wr_tgt     (wr_tgt),
        .wr_ctr     (wr_ctr)
    );

    btb_redirect_fsm #(.PC_W(PC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mispredict (mispredict),
        .correct_pc (correct_pc),
        .accept     (accept),
        .flush      (flush),
        .stall      (stall),
        .redirect   (redirect),
        .fix_pc     (fix_pc)
    );

    assign hit        = a_hit;
    assign pred_taken = a_hit && a_ctr[1];

    btb_next_pc_mux #(.PC_W(PC_W)) u_mux (
        .fetch_pc   (fetch_pc),
        .pred_taken (pred_taken),
        .pred_tgt   (a_tgt),
        .stall      (stall),
        .redirect   (redirect),
        .fix_pc     (fix_pc),
        .next_pc    (next_pc)
    );

    // R7: an accepted misprediction raises flush on the next cycle.
    a_r7_mispredict_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> flush);
    // R8: the redirect cycle carries the true next address of the resolve.
    a_r8_redirect_address: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> ##1 (redirect && (next_pc == $past(correct_pc, 2))));

endmodule

// File: tb/tb_btb_fetch_unit.sv
module tb_btb_fetch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 16;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            resolve_valid = 1'b0;
    logic [PC_W-1:0] resolve_pc = '0;
    logic            resolve_taken = 1'b0;
    logic [PC_W-1:0] resolve_target = '0;
    logic            hit, pred_taken, flush, stall, redirect;
    logic [PC_W-1:0] next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_fetch_unit #(.PC_W(PC_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
        .resolve_taken(resolve_taken), .resolve_target(resolve_target),
        .hit(hit), .pred_taken(pred_taken), .next_pc(next_pc),
        .flush(flush), .stall(stall), .redirect(redirect)
    );

    // Reference model of the table
    logic            m_v   [DEPTH];
    logic [10:0]     m_tag [DEPTH];
    logic [PC_W-1:0] m_tgt [DEPTH];
    logic [1:0]      m_ctr [DEPTH];

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    function automatic logic m_hit(input logic [PC_W-1:0] pc);
        return m_v[idx_of(pc)] && (m_tag[idx_of(pc)] == pc[PC_W-1:IDX_W+2]);
    endfunction

    function automatic logic m_ptk(input logic [PC_W-1:0] pc);
        return m_hit(pc) && m_ctr[idx_of(pc)][1];
    endfunction

    function automatic logic [PC_W-1:0] m_next(input logic [PC_W-1:0] pc);
        return m_ptk(pc) ? m_tgt[idx_of(pc)] : pc + 16'd4;
    endfunction

    function automatic logic [PC_W-1:0] m_true(input logic [PC_W-1:0] pc, input logic tk,
                                               input logic [PC_W-1:0] tg);
        return tk ? tg : pc + 16'd4;
    endfunction

    task automatic m_update(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tg);
        int i = idx_of(pc);
        if (m_hit(pc)) begin
            if (tk) begin
                m_ctr[i] = (m_ctr[i] == 2'd3) ? 2'd3 : m_ctr[i] + 2'd1;
                m_tgt[i] = tg;
            end else begin
                m_ctr[i] = (m_ctr[i] == 2'd0) ? 2'd0 : m_ctr[i] - 2'd1;
            end
        end else if (tk) begin
            m_v[i]   = 1'b1;
            m_tag[i] = pc[PC_W-1:IDX_W+2];
            m_tgt[i] = tg;
            m_ctr[i] = 2'd2;
        end
    endtask

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] mk(input int tag, input int idx);
        return PC_W'((tag << (IDX_W + 2)) | (idx << 2));
    endfunction

    // Lookup: R3 on predicted-taken hits, R4 otherwise, R2 via tag match.
    task automatic lookup(input logic [PC_W-1:0] pc);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        check("R2 hit", 32'(hit), 32'(m_hit(pc)));
        if (m_ptk(pc)) begin
            check("R3 pred_taken", 32'(pred_taken), 32'd1);
            check("R3 next_pc", 32'(next_pc), 32'(m_next(pc)));
        end else begin
            check("R4 pred_taken", 32'(pred_taken), 32'd0);
            check("R4 next_pc", 32'(next_pc), 32'(pc + 16'd4));
        end
    endtask

    // Resolve one branch and follow the penalty sequence (R7, R8, R11).
    task automatic resolve(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tg);
        logic mis;
        logic [PC_W-1:0] fix;
        @(negedge clk);
        resolve_valid = 1'b1; resolve_pc = pc; resolve_taken = tk; resolve_target = tg;
        mis = (m_next(pc) != m_true(pc, tk, tg));
        fix = m_true(pc, tk, tg);
        @(negedge clk);
        resolve_valid = 1'b0;
        m_update(pc, tk, tg);
        if (mis) begin
            check("R7 flush on mispredict", 32'(flush), 32'd1);
            check("R8 stall in flush cycle", 32'(stall), 32'd1);
            check("R8 hold pc", 32'(next_pc), 32'(fetch_pc));
            @(negedge clk);
            check("R8 redirect", 32'(redirect), 32'd1);
            check("R8 redirect pc", 32'(next_pc), 32'(fix));
            @(negedge clk);
            check("R8 back to run", 32'({flush, stall, redirect}), 32'd0);
        end else begin
            check("R11 no penalty", 32'({flush, stall, redirect}), 32'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state over every index
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            fetch_pc = mk(5, i);
            #1;
            check("R1 miss after reset", 32'(hit), 32'd0);
            check("R1 next_pc", 32'(next_pc), 32'(mk(5, i) + 16'd4));
            check("R1 no penalty", 32'({flush, stall, redirect, pred_taken}), 32'd0);
        end

        // R5: fill every index with a taken branch, then look it up
        for (int i = 0; i < DEPTH; i++) begin
            resolve(mk(5, i), 1'b1, PC_W'(16'h4000 + i * 8));
            check("R5 fill visible", 32'(m_hit(mk(5, i))), 32'd1);
            lookup(mk(5, i));
        end

        // R2: aliasing tags miss
        for (int i = 0; i < DEPTH; i++) lookup(mk(9, i));

        // R5: not-taken miss leaves table unchanged
        resolve(mk(9, 0), 1'b0, 16'h1234);
        lookup(mk(9, 0));
        lookup(mk(5, 0));

        // R6: counter walk on index 1, all outcome patterns
        begin
            logic pat [10] = '{1,1,0,0,0,0,1,1,1,0};
            for (int k = 0; k < 10; k++) begin
                resolve(mk(5, 1), pat[k], 16'h4008);
                lookup(mk(5, 1));
            end
        end

        // R6/R7: hit-taken with a new destination
        resolve(mk(5, 2), 1'b1, 16'h5550);
        lookup(mk(5, 2));

        // R9: a resolve during the flush cycle is dropped
        begin
            logic [PC_W-1:0] x = mk(7, 5);
            logic [PC_W-1:0] y = mk(7, 6);
            @(negedge clk);
            resolve_valid = 1'b1; resolve_pc = x; resolve_taken = 1'b1; resolve_target = 16'h6000;
            @(negedge clk);
            m_update(x, 1'b1, 16'h6000);
            check("R9 flush from first resolve", 32'(flush), 32'd1);
            resolve_pc = y; resolve_target = 16'h6100;
            @(negedge clk);
            resolve_valid = 1'b0;
            check("R9 redirect", 32'(redirect), 32'd1);
            @(negedge clk);
            check("R9 no second penalty", 32'({flush, stall, redirect}), 32'd0);
            lookup(y);
            check("R9 ignored resolve not stored", 32'(hit), 32'd0);
            lookup(mk(5, 6));
        end

        // R10: same-slot lookup and write in one cycle
        begin
            logic [PC_W-1:0] z = mk(3, 7);
            @(negedge clk);
            fetch_pc = z;
            resolve_valid = 1'b1; resolve_pc = z; resolve_taken = 1'b1; resolve_target = 16'h7700;
            #1;
            check("R10 old contents", 32'(hit), 32'd0);
            @(negedge clk);
            resolve_valid = 1'b0;
            m_update(z, 1'b1, 16'h7700);
            check("R10 new contents", 32'(hit), 32'd1);
            @(negedge clk);
            @(negedge clk);
            lookup(z);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule